// File: doc/BRIEF.md
# Bidirectional GPIO Port

An eight-pin general-purpose I/O port with a small register interface on the CPU side and, for each pin, the control signals of a tri-state pad on the other. Each pin has an output latch bit, a direction bit and a two-stage input synchronizer. The direction bit alone enables the pad driver. The latch bit is always presented as the output value, so a value loaded while the pin is an input shows up the moment the driver is switched on. While a pin is an input, its latch bit also switches its pull-up.

The pin level is sampled whatever the direction, so software reads the real pad level rather than the latch. For a pin that is an output, a monitor compares the sampled level with the latch. A mismatch that lasts longer than a programmable settling window sets a sticky per-pin fault flag, for example when a high output is shorted to ground. Software clears a flag by writing 1 to it.

Top module: `gpio_port`

## Requirements
- R1: After a write to the direction register (address 1), `pin_oe` equals the written value from the next clock edge on. Bit 1 means output with the driver enabled, bit 0 means input with the driver off.
- R2: Writes to any address other than 0 leave the latch unchanged. A direction change never alters the latch, and reading address 0 returns it.
- R3: A data write (address 0) to a pin that is an input is stored in its latch but leaves `pin_oe` at 0.
- R4: `pin_out` always equals the latch. When a pin turns into an output, its preloaded latch value is on `pin_out` in the same cycle that `pin_oe` rises.
- R5: `pin_pu` for a pin is 1 exactly when that pin is an input and its latch bit is 1. It is always 0 for an output pin.
- R6: Reading address 2 returns the pin level through two flip-flops, whatever the direction. A change on `pin_in` shows up after the second clock edge, not after the first.
- R7: Address map: 0 is the data latch, 1 is direction, 2 is the sampled pins (read-only, so writes to it change nothing) and 3 is the fault flags. `reg_rdata` follows `reg_addr` combinationally.
- R8: With `settle_limit` = L, the fault flag of an output pin whose pad level stays different from its latch sets on the (L+3)-th clock edge after the pad changes, and not earlier. Two of those edges come from the synchronizer and L+1 are consecutive mismatch edges.
- R9: Input pins never raise a fault. A mismatch that goes away restarts the settling count, so short mismatch runs separated by good cycles never set a flag.
- R10: Fault flags are sticky. Writing 1 to a bit of address 3 clears it and writing 0 has no effect. If a clear and a set happen in the same cycle, the set wins.
- R11: After reset, all pins are inputs, the latch is 0, the pull-ups are off, the synchronizers are 0 and no fault is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 data, 1 direction, 2 pins, 3 faults) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| settle_limit | input | 8 | Extra mismatch cycles tolerated before a fault |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Value for the pad drivers |
| pin_oe | output | 8 | Driver enables, 1 drives the pad |
| pin_pu | output | 8 | Pull-up enables |
| fault | output | 8 | Sticky latch-versus-pad mismatch flags |

## Verification
Register effects on `pin_oe`, `pin_out` and `pin_pu` are due one edge after the write, so the bench samples them one time unit after that edge. A pin change is due on the read port after exactly two edges, and the bench samples after the first edge, where the old value is expected, and after the second. The fault flag is due on edge L+3 after a short is applied. For L from 0 to 4, the bench checks the flag at every edge up to and including that one, so a flag that sets too early or too late is caught. The stickiness, the set-over-clear priority and the restarting of an interrupted count are checked one edge after each stimulus.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    typedef enum logic [1:0] {
        SEL_DATA  = 2'd0,
        SEL_DIR   = 2'd1,
        SEL_PIN   = 2'd2,
        SEL_FAULT = 2'd3
    } gpio_sel_e;
endpackage

// File: rtl/gpio_ctrl_regs.sv
// Output latch and direction register of the port.
module gpio_ctrl_regs #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr,
    input  logic [1:0]   sel,
    input  logic [N-1:0] wdata,
    output logic [N-1:0] latch,
    output logic [N-1:0] dir
);
    import gpio_pkg::*;

    typedef struct packed {
        logic [N-1:0] latch;
        logic [N-1:0] dir;
    } regs_t;

    regs_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr && sel == SEL_DATA) s_d.latch = wdata;
        if (wr && sel == SEL_DIR)  s_d.dir   = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign latch = s_q.latch;
    assign dir   = s_q.dir;
endmodule

// File: rtl/gpio_in_sync.sv
// Multi-stage input synchronizer, one chain per pin.
module gpio_in_sync #(
    parameter int N      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin_in,
    output logic [N-1:0] sensed
);
    localparam int LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][N-1:0] stage;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.stage[0] = pin_in;
        for (int k = 1; k < STAGES; k++) s_d.stage[k] = s_q.stage[k-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sensed = s_q.stage[LAST];
endmodule

// File: rtl/gpio_fault_mon.sv
// Per-pin mismatch counter with a sticky flag, cleared by writing 1.
module gpio_fault_mon #(
    parameter int N  = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  drive_en,
    input  logic [N-1:0]  latch,
    input  logic [N-1:0]  sensed,
    input  logic [CW-1:0] limit,
    input  logic [N-1:0]  clr,
    output logic [N-1:0]  flag
);
    for (genvar i = 0; i < N; i++) begin : g_pin
        typedef struct packed {
            logic [CW-1:0] cnt;
            logic          flag;
        } mon_t;

        mon_t s_d, s_q;
        logic mis;

        assign mis = drive_en[i] && (sensed[i] != latch[i]);

        always_comb begin
            s_d = s_q;
            if (!mis)                s_d.cnt = '0;
            else if (s_q.cnt < limit) s_d.cnt = s_q.cnt + 1'b1;
            if (clr[i])              s_d.flag = 1'b0;
            if (mis && s_q.cnt >= limit) s_d.flag = 1'b1;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) s_q <= '0;
            else        s_q <= s_d;
        end

        assign flag[i] = s_q.flag;
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int N  = 8,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [1:0]    reg_addr,
    input  logic [N-1:0]  reg_wdata,
    output logic [N-1:0]  reg_rdata,
    input  logic [CW-1:0] settle_limit,
    input  logic [N-1:0]  pin_in,
    output logic [N-1:0]  pin_out,
    output logic [N-1:0]  pin_oe,
    output logic [N-1:0]  pin_pu,
    output logic [N-1:0]  fault
);
    import gpio_pkg::*;

    logic [N-1:0] latch, dir, sensed, clr;

    gpio_ctrl_regs #(.N(N)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_addr),
        .wdata(reg_wdata), .latch(latch), .dir(dir)
    );

    gpio_in_sync #(.N(N), .STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .sensed(sensed)
    );

    assign clr = (reg_wr && reg_addr == SEL_FAULT) ? reg_wdata : '0;

    gpio_fault_mon #(.N(N), .CW(CW)) u_mon (
        .clk(clk), .rst_n(rst_n), .drive_en(dir), .latch(latch),
        .sensed(sensed), .limit(settle_limit), .clr(clr), .flag(fault)
    );

    assign pin_out = latch;
    assign pin_oe  = dir;
    assign pin_pu  = latch & ~dir;

    always_comb begin
        unique case (reg_addr)
            SEL_DATA: reg_rdata = latch;
            SEL_DIR:  reg_rdata = dir;
            SEL_PIN:  reg_rdata = sensed;
            default:  reg_rdata = fault;
        endcase
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int N  = 8,
    parameter int CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_wr,
    input logic [1:0]    reg_addr,
    input logic [N-1:0]  reg_wdata,
    input logic [N-1:0]  reg_rdata,
    input logic [CW-1:0] settle_limit,
    input logic [N-1:0]  pin_in,
    input logic [N-1:0]  pin_out,
    input logic [N-1:0]  pin_oe,
    input logic [N-1:0]  pin_pu,
    input logic [N-1:0]  fault
);
    p_oe_follows_dir_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd1) |=> (pin_oe == $past(reg_wdata)));

    p_latch_kept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr && reg_addr == 2'd0)) |=> $stable(pin_out));

    p_pu_off_when_out_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_pu & pin_oe) == '0));

    p_pin_reg_ro_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 2'd2) |=> ($stable(pin_out) && $stable(pin_oe)));

    p_no_input_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((fault & ~$past(fault) & ~$past(pin_oe)) == '0));

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(reg_wr && reg_addr == 2'd3)) |=> ((fault & $past(fault)) == $past(fault)));
endmodule

bind gpio_port gpio_port_chk #(.N(N), .CW(CW)) u_chk (.*);

// File: tb/sim_gpio_port.sv
`timescale 1ns/1ps
module sim_gpio_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic [7:0] settle_limit = 8'd0;
    logic [7:0] pin_in, pin_out, pin_oe, pin_pu, fault;
    logic [7:0] ext_en = '0, ext_val = '0, short_gnd = '0;
    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    // pad model: short wins, then own driver, then external driver, then pull-up
    always_comb begin
        for (int i = 0; i < 8; i++)
            pin_in[i] = short_gnd[i] ? 1'b0 : pin_oe[i] ? pin_out[i] :
                        ext_en[i] ? ext_val[i] : pin_pu[i];
    end

    gpio_port u0 (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        logic [7:0] r, prev, v;
        step(3);
        rst_n = 1'b1;
        step(1);
        // R11 reset state
        rd(2'd0, r); chk("R11 data", r, 8'h00);
        rd(2'd1, r); chk("R11 dir", r, 8'h00);
        rd(2'd2, r); chk("R11 pins", r, 8'h00);
        rd(2'd3, r); chk("R11 fault", r, 8'h00);
        chk("R11 oe", pin_oe, 8'h00);
        chk("R11 pu", pin_pu, 8'h00);

        settle_limit = 8'd255;
        // R3 / R5: latch writes on input pins
        for (int i = 0; i < 256; i++) begin
            wr(2'd0, 8'(i));
            chk("R3 oe stays off", pin_oe, 8'h00);
            chk("R5 pull-up", pin_pu, 8'(i));
            rd(2'd0, r); chk("R3 latch stored", r, 8'(i));
        end
        // R1 / R2 / R4 / R5: direction sweep with a fixed latch
        wr(2'd0, 8'hA5);
        for (int i = 0; i < 256; i++) begin
            wr(2'd1, 8'(i));
            chk("R1 oe", pin_oe, 8'(i));
            chk("R4 out", pin_out, 8'hA5);
            chk("R5 pu masked", pin_pu, 8'hA5 & ~8'(i));
            rd(2'd0, r); chk("R2 latch kept", r, 8'hA5);
            rd(2'd1, r); chk("R7 dir read", r, 8'(i));
        end
        // R4 preload then enable
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h3C);
        chk("R4 preload no drive", pin_oe, 8'h00);
        wr(2'd1, 8'hFF);
        chk("R4 oe up", pin_oe, 8'hFF);
        chk("R4 preloaded value", pin_out, 8'h3C);
        // R7 pin register is read-only
        wr(2'd2, 8'hC3);
        rd(2'd0, r); chk("R7 data after pin write", r, 8'h3C);
        rd(2'd1, r); chk("R7 dir after pin write", r, 8'hFF);

        // R6 input sampling lag
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h00);
        ext_en = 8'hFF; ext_val = 8'h00; prev = 8'h00;
        step(3);
        for (int i = 0; i < 64; i++) begin
            v = 8'((i * 53 + 7) & 255);
            ext_val = v;
            step(1); rd(2'd2, r); chk("R6 one edge old", r, prev);
            step(1); rd(2'd2, r); chk("R6 two edges new", r, v);
            prev = v;
        end
        // R6 readback of output pins under shorts
        ext_en = 8'h00;
        wr(2'd0, 8'hFF);
        wr(2'd1, 8'hFF);
        for (int i = 0; i < 16; i++) begin
            v = 8'((i * 29 + 1) & 255);
            short_gnd = v;
            step(2); rd(2'd2, r); chk("R6 real level", r, 8'hFF & ~v);
        end
        short_gnd = 8'h00;
        step(3);

        // R8 / R10 fault timing per limit
        for (int L = 0; L < 5; L++) begin
            settle_limit = 8'(L);
            wr(2'd3, 8'hFF); step(1);
            rd(2'd3, r); chk("R10 cleared before test", r, 8'h00);
            short_gnd = 8'(1 << L);
            for (int k = 1; k <= L + 3; k++) begin
                step(1);
                chk("R8 fault timing", fault, (k == L + 3) ? 8'(1 << L) : 8'h00);
            end
            wr(2'd3, 8'(1 << L));
            chk("R10 set beats clear", fault, 8'(1 << L));
            short_gnd = 8'h00;
            step(4);
            chk("R10 sticky", fault, 8'(1 << L));
            wr(2'd3, 8'h00);
            chk("R10 write 0 no effect", fault, 8'(1 << L));
            wr(2'd3, 8'(1 << L));
            chk("R10 write 1 clears", fault, 8'h00);
        end

        // R9 interrupted mismatch restarts count
        settle_limit = 8'd4;
        short_gnd = 8'h01; step(4);
        short_gnd = 8'h00; step(4);
        short_gnd = 8'h01; step(4);
        short_gnd = 8'h00; step(6);
        chk("R9 count restarts", fault, 8'h00);
        // R9 input pins never fault
        settle_limit = 8'd0;
        wr(2'd1, 8'h00);
        ext_en = 8'hFF; ext_val = 8'h00;
        step(10);
        chk("R9 input no fault", fault, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule